// File: doc/BRIEF.md
# Three-Class Heterogeneous Link Port

This block is the transmit and receive path of one port on a link whose wires come in three classes. The low-latency class is narrow and fast, the baseline class is of medium width, and the power-efficient class is wide and slow. Messages that have already been classified come in on three valid/ready enqueue ports, one for each class. Each class has its own small queue, its own serializer and its own pipeline of latches, so each cycle up to three messages can leave the port at the same time, one on each bundle. The messages can differ in width and in latency.

A message wider than its bundle is cut into flits of bundle width. The flits go out in consecutive cycles, least significant bits first, and the last flit carries a marker. The receive half takes flits from the far end on bundle inputs of the same shape. It puts each message back together and presents it as a one-cycle delivery pulse. Each queue reports its occupancy, and the port outputs the sum of the three as a congestion measure for the wire-selection logic upstream.

Top module: `hetlink_port`

## Requirements
- R1: After synchronous reset all three enqueue readies are high, every occupancy and the total are zero, and no bundle or delivery valid is asserted.
- R2: Each class queue holds DEPTH (default 4) messages. A class's ready is low only while its own queue holds DEPTH messages, and the other classes go on accepting and sending.
- R3: In one cycle each class launches at most one flit, and all three classes can launch in the same cycle.
- R4: By default the bundles are 24 bits (low-latency), 256 bits (baseline) and 512 bits (power-efficient) wide. The message widths are 48, 512 and 512 bits.
- R5: A flit launched from a queue head at clock edge e is on the bundle output after edge e+S-1. S is the class's stage count: 1 for low-latency, 2 for baseline, 4 for power-efficient. A message accepted into an empty queue at edge k launches its first flit at edge k+1.
- R6: A message is sent as ceil(message width / bundle width) flits in consecutive cycles. Flit i carries bits [i*W +: W], with zero padding above the message. The last flit has its last marker set. The message stays at the queue head until its last flit launches.
- R7: The receive side shows a reassembled message on its delivery port for exactly one cycle. This is the cycle after the clock edge that samples the bundle input flit marked last.
- R8: Within one class, messages are delivered in the order they were accepted. There is no ordering between classes.
- R9: A class's occupancy counts the messages it has accepted whose last flit has not yet launched. The total output is the sum of the three occupancies.
- R10: An enqueue offered while that class's ready is low has no effect. It is never sent or delivered, and the occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network clock |
| rst | input | 1 | Synchronous active-high reset |
| l_in_valid | input | 1 | Low-latency enqueue valid |
| l_in_ready | output | 1 | Low-latency queue has room |
| l_in_data | input | L_MSG_W | Low-latency message |
| b_in_valid | input | 1 | Baseline enqueue valid |
| b_in_ready | output | 1 | Baseline queue has room |
| b_in_data | input | B_MSG_W | Baseline message |
| pw_in_valid | input | 1 | Power-efficient enqueue valid |
| pw_in_ready | output | 1 | Power-efficient queue has room |
| pw_in_data | input | PW_MSG_W | Power-efficient message |
| l_tx_valid | output | 1 | Low-latency bundle flit valid |
| l_tx_last | output | 1 | Low-latency flit ends its message |
| l_tx_data | output | L_LINK_W | Low-latency bundle flit |
| b_tx_valid | output | 1 | Baseline bundle flit valid |
| b_tx_last | output | 1 | Baseline flit ends its message |
| b_tx_data | output | B_LINK_W | Baseline bundle flit |
| pw_tx_valid | output | 1 | Power-efficient bundle flit valid |
| pw_tx_last | output | 1 | Power-efficient flit ends its message |
| pw_tx_data | output | PW_LINK_W | Power-efficient bundle flit |
| l_lk_valid | input | 1 | Received low-latency flit valid |
| l_lk_last | input | 1 | Received low-latency flit is last |
| l_lk_data | input | L_LINK_W | Received low-latency flit |
| b_lk_valid | input | 1 | Received baseline flit valid |
| b_lk_last | input | 1 | Received baseline flit is last |
| b_lk_data | input | B_LINK_W | Received baseline flit |
| pw_lk_valid | input | 1 | Received power-efficient flit valid |
| pw_lk_last | input | 1 | Received power-efficient flit is last |
| pw_lk_data | input | PW_LINK_W | Received power-efficient flit |
| l_dlv_valid | output | 1 | Low-latency message delivered |
| l_dlv_data | output | L_MSG_W | Delivered low-latency message |
| b_dlv_valid | output | 1 | Baseline message delivered |
| b_dlv_data | output | B_MSG_W | Delivered baseline message |
| pw_dlv_valid | output | 1 | Power-efficient message delivered |
| pw_dlv_data | output | PW_MSG_W | Delivered power-efficient message |
| l_occ | output | OCC_W | Low-latency queue occupancy |
| b_occ | output | OCC_W | Baseline queue occupancy |
| pw_occ | output | OCC_W | Power-efficient queue occupancy |
| occ_total | output | OCC_W+2 | Sum of the three occupancies |

## Verification
The bench loops the bundles back into the receive inputs. It floods every class at once so that the two-flit classes fill while the single-flit class keeps draining. A design that tied the readies together would stall the power-efficient queue, and one that popped the head after its first flit would drop the upper half of two-flit messages. Offers made against a full queue must vanish without a trace: a queue that overwrote its head or counted the offer would show the wrong occupancy or deliver a message that was never accepted. Flit timing is compared on every cycle against each class's own stage count. This catches an off-by-one latch count, an enqueue-to-launch bypass, and the case where a push and a pop in the same cycle leave the occupancy wrong.

// File: rtl/hetlink_pkg.sv
package hetlink_pkg;

    // Number of bundle-wide flits needed to carry one message.
    function automatic int flits_for(input int msg_w, input int link_w);
        return (msg_w + link_w - 1) / link_w;
    endfunction

    // Width of an index that counts 0..n-1 (at least one bit).
    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Width of an occupancy counter that reaches depth.
    function automatic int occ_bits(input int depth);
        return $clog2(depth + 1);
    endfunction

    // Flit as it travels down a class pipeline.
    typedef struct packed {
        logic last;
        logic valid;
    } flit_tag_t;

endpackage

// File: rtl/hl_msg_queue.sv
module hl_msg_queue
    import hetlink_pkg::*;
#(
    parameter int WIDTH = 24,
    parameter int DEPTH = 4,
    localparam int PTR_W = idx_bits(DEPTH),
    localparam int CNT_W = occ_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    output logic             push_ready,
    output logic             head_valid,
    output logic [WIDTH-1:0] head_data,
    input  logic             pop,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_fire;
    logic             pop_fire;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ready = (count < CNT_W'(DEPTH));
    assign head_valid = (count != '0);
    assign head_data  = mem[rd_ptr];
    assign push_fire  = push_valid && push_ready;
    assign pop_fire   = pop && head_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_fire) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop_fire) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CNT_W'(push_fire) - CNT_W'(pop_fire);
        end
    end
endmodule

// File: rtl/hl_flit_serializer.sv
module hl_flit_serializer
    import hetlink_pkg::*;
#(
    parameter int MSG_W  = 48,
    parameter int LINK_W = 24,
    localparam int NF    = flits_for(MSG_W, LINK_W),
    localparam int IDX_W = idx_bits(NF),
    localparam int PAD_W = NF * LINK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              head_valid,
    input  logic [MSG_W-1:0]  head_data,
    output logic              pop,
    output logic              flit_valid,
    output logic              flit_last,
    output logic [LINK_W-1:0] flit_data
);
    logic [IDX_W-1:0] idx;
    logic [PAD_W-1:0] padded;

    assign padded     = PAD_W'(head_data);
    assign flit_data  = padded[int'(idx) * LINK_W +: LINK_W];
    assign flit_last  = (int'(idx) == NF - 1);
    assign flit_valid = head_valid;
    assign pop        = head_valid && flit_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (head_valid) begin
            idx <= flit_last ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/hl_stage_pipe.sv
module hl_stage_pipe
    import hetlink_pkg::*;
#(
    parameter int WIDTH  = 24,
    parameter int STAGES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  flit_tag_t        in_tag,
    input  logic [WIDTH-1:0] in_data,
    output flit_tag_t        out_tag,
    output logic [WIDTH-1:0] out_data
);
    flit_tag_t        st_tag  [STAGES];
    logic [WIDTH-1:0] st_data [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_tag[0]  <= '0;
                    st_data[0] <= '0;
                end else begin
                    st_tag[0]  <= in_tag;
                    st_data[0] <= in_data;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_tag[s]  <= '0;
                    st_data[s] <= '0;
                end else begin
                    st_tag[s]  <= st_tag[s-1];
                    st_data[s] <= st_data[s-1];
                end
            end
        end
    end

    assign out_tag  = st_tag[STAGES-1];
    assign out_data = st_data[STAGES-1];
endmodule

// File: rtl/hl_flit_assembler.sv
module hl_flit_assembler
    import hetlink_pkg::*;
#(
    parameter int MSG_W  = 48,
    parameter int LINK_W = 24,
    localparam int NF    = flits_for(MSG_W, LINK_W),
    localparam int IDX_W = idx_bits(NF),
    localparam int PAD_W = NF * LINK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [LINK_W-1:0] in_data,
    output logic              out_valid,
    output logic [MSG_W-1:0]  out_data
);
    logic [PAD_W-1:0] acc;
    logic [PAD_W-1:0] merged;
    logic [IDX_W-1:0] idx;

    always_comb begin
        merged = acc;
        merged[int'(idx) * LINK_W +: LINK_W] = in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            idx       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid && in_last;
            if (in_valid) begin
                acc <= merged;
                idx <= in_last ? '0 : idx + 1'b1;
                if (in_last) begin
                    out_data <= MSG_W'(merged);
                end
            end
        end
    end
endmodule

// File: rtl/hl_lane.sv
module hl_lane
    import hetlink_pkg::*;
#(
    parameter int MSG_W  = 48,
    parameter int LINK_W = 24,
    parameter int STAGES = 1,
    parameter int DEPTH  = 4,
    localparam int OCC_W = occ_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [MSG_W-1:0]  in_data,
    output logic              tx_valid,
    output logic              tx_last,
    output logic [LINK_W-1:0] tx_data,
    input  logic              lk_valid,
    input  logic              lk_last,
    input  logic [LINK_W-1:0] lk_data,
    output logic              dlv_valid,
    output logic [MSG_W-1:0]  dlv_data,
    output logic [OCC_W-1:0]  occ
);
    logic              head_valid;
    logic [MSG_W-1:0]  head_data;
    logic              head_pop;
    flit_tag_t         launch_tag;
    logic [LINK_W-1:0] launch_data;
    flit_tag_t         wire_tag;

    hl_msg_queue #(.WIDTH(MSG_W), .DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push_valid (in_valid),
        .push_data  (in_data),
        .push_ready (in_ready),
        .head_valid (head_valid),
        .head_data  (head_data),
        .pop        (head_pop),
        .count      (occ)
    );

    hl_flit_serializer #(.MSG_W(MSG_W), .LINK_W(LINK_W)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .head_valid (head_valid),
        .head_data  (head_data),
        .pop        (head_pop),
        .flit_valid (launch_tag.valid),
        .flit_last  (launch_tag.last),
        .flit_data  (launch_data)
    );

    hl_stage_pipe #(.WIDTH(LINK_W), .STAGES(STAGES)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_tag   (launch_tag),
        .in_data  (launch_data),
        .out_tag  (wire_tag),
        .out_data (tx_data)
    );

    assign tx_valid = wire_tag.valid;
    assign tx_last  = wire_tag.valid && wire_tag.last;

    hl_flit_assembler #(.MSG_W(MSG_W), .LINK_W(LINK_W)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (lk_valid),
        .in_last   (lk_last),
        .in_data   (lk_data),
        .out_valid (dlv_valid),
        .out_data  (dlv_data)
    );
endmodule

// File: rtl/hetlink_port.sv
module hetlink_port
    import hetlink_pkg::*;
#(
    parameter int L_MSG_W   = 48,
    parameter int B_MSG_W   = 512,
    parameter int PW_MSG_W  = 512,
    parameter int L_LINK_W  = 24,
    parameter int B_LINK_W  = 256,
    parameter int PW_LINK_W = 512,
    parameter int L_STAGES  = 1,
    parameter int B_STAGES  = 2,
    parameter int PW_STAGES = 4,
    parameter int DEPTH     = 4,
    localparam int OCC_W    = occ_bits(DEPTH),
    localparam int TOT_W    = OCC_W + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 l_in_valid,
    output logic                 l_in_ready,
    input  logic [L_MSG_W-1:0]   l_in_data,
    input  logic                 b_in_valid,
    output logic                 b_in_ready,
    input  logic [B_MSG_W-1:0]   b_in_data,
    input  logic                 pw_in_valid,
    output logic                 pw_in_ready,
    input  logic [PW_MSG_W-1:0]  pw_in_data,
    output logic                 l_tx_valid,
    output logic                 l_tx_last,
    output logic [L_LINK_W-1:0]  l_tx_data,
    output logic                 b_tx_valid,
    output logic                 b_tx_last,
    output logic [B_LINK_W-1:0]  b_tx_data,
    output logic                 pw_tx_valid,
    output logic                 pw_tx_last,
    output logic [PW_LINK_W-1:0] pw_tx_data,
    input  logic                 l_lk_valid,
    input  logic                 l_lk_last,
    input  logic [L_LINK_W-1:0]  l_lk_data,
    input  logic                 b_lk_valid,
    input  logic                 b_lk_last,
    input  logic [B_LINK_W-1:0]  b_lk_data,
    input  logic                 pw_lk_valid,
    input  logic                 pw_lk_last,
    input  logic [PW_LINK_W-1:0] pw_lk_data,
    output logic                 l_dlv_valid,
    output logic [L_MSG_W-1:0]   l_dlv_data,
    output logic                 b_dlv_valid,
    output logic [B_MSG_W-1:0]   b_dlv_data,
    output logic                 pw_dlv_valid,
    output logic [PW_MSG_W-1:0]  pw_dlv_data,
    output logic [OCC_W-1:0]     l_occ,
    output logic [OCC_W-1:0]     b_occ,
    output logic [OCC_W-1:0]     pw_occ,
    output logic [TOT_W-1:0]     occ_total
);
    hl_lane #(.MSG_W(L_MSG_W), .LINK_W(L_LINK_W), .STAGES(L_STAGES), .DEPTH(DEPTH)) u_lane_l (
        .clk (clk), .rst (rst),
        .in_valid (l_in_valid), .in_ready (l_in_ready), .in_data (l_in_data),
        .tx_valid (l_tx_valid), .tx_last (l_tx_last), .tx_data (l_tx_data),
        .lk_valid (l_lk_valid), .lk_last (l_lk_last), .lk_data (l_lk_data),
        .dlv_valid (l_dlv_valid), .dlv_data (l_dlv_data),
        .occ (l_occ)
    );

    hl_lane #(.MSG_W(B_MSG_W), .LINK_W(B_LINK_W), .STAGES(B_STAGES), .DEPTH(DEPTH)) u_lane_b (
        .clk (clk), .rst (rst),
        .in_valid (b_in_valid), .in_ready (b_in_ready), .in_data (b_in_data),
        .tx_valid (b_tx_valid), .tx_last (b_tx_last), .tx_data (b_tx_data),
        .lk_valid (b_lk_valid), .lk_last (b_lk_last), .lk_data (b_lk_data),
        .dlv_valid (b_dlv_valid), .dlv_data (b_dlv_data),
        .occ (b_occ)
    );

    hl_lane #(.MSG_W(PW_MSG_W), .LINK_W(PW_LINK_W), .STAGES(PW_STAGES), .DEPTH(DEPTH)) u_lane_pw (
        .clk (clk), .rst (rst),
        .in_valid (pw_in_valid), .in_ready (pw_in_ready), .in_data (pw_in_data),
        .tx_valid (pw_tx_valid), .tx_last (pw_tx_last), .tx_data (pw_tx_data),
        .lk_valid (pw_lk_valid), .lk_last (pw_lk_last), .lk_data (pw_lk_data),
        .dlv_valid (pw_dlv_valid), .dlv_data (pw_dlv_data),
        .occ (pw_occ)
    );

    assign occ_total = TOT_W'(l_occ) + TOT_W'(b_occ) + TOT_W'(pw_occ);
endmodule

// File: rtl/hetlink_port_chk.sv
module hetlink_port_chk
    import hetlink_pkg::*;
#(
    parameter int DEPTH  = 4,
    localparam int OCC_W = occ_bits(DEPTH),
    localparam int TOT_W = OCC_W + 2
) (
    input logic             clk,
    input logic             rst,
    input logic             l_in_valid,
    input logic             l_in_ready,
    input logic             b_in_valid,
    input logic             b_in_ready,
    input logic             pw_in_valid,
    input logic             pw_in_ready,
    input logic             l_tx_valid,
    input logic             l_tx_last,
    input logic             b_tx_valid,
    input logic             b_tx_last,
    input logic             pw_tx_valid,
    input logic             pw_tx_last,
    input logic             l_lk_valid,
    input logic             l_lk_last,
    input logic             b_lk_valid,
    input logic             b_lk_last,
    input logic             pw_lk_valid,
    input logic             pw_lk_last,
    input logic             l_dlv_valid,
    input logic             b_dlv_valid,
    input logic             pw_dlv_valid,
    input logic [OCC_W-1:0] l_occ,
    input logic [OCC_W-1:0] b_occ,
    input logic [OCC_W-1:0] pw_occ,
    input logic [TOT_W-1:0] occ_total
);
    // R1: first cycle out of reset is idle
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (occ_total == '0 && !l_tx_valid && !b_tx_valid && !pw_tx_valid));

    // R2: occupancy never exceeds the queue depth
    a_r2_l_bound:  assert property (@(posedge clk) disable iff (rst) int'(l_occ)  <= DEPTH);
    a_r2_b_bound:  assert property (@(posedge clk) disable iff (rst) int'(b_occ)  <= DEPTH);
    a_r2_pw_bound: assert property (@(posedge clk) disable iff (rst) int'(pw_occ) <= DEPTH);

    // R9: occupancy moves by at most one per cycle
    a_r9_l_step: assert property (@(posedge clk) disable iff (rst)
        int'(l_occ) <= int'($past(l_occ)) + 1 && int'(l_occ) + 1 >= int'($past(l_occ)));
    a_r9_b_step: assert property (@(posedge clk) disable iff (rst)
        int'(b_occ) <= int'($past(b_occ)) + 1 && int'(b_occ) + 1 >= int'($past(b_occ)));
    a_r9_pw_step: assert property (@(posedge clk) disable iff (rst)
        int'(pw_occ) <= int'($past(pw_occ)) + 1 && int'(pw_occ) + 1 >= int'($past(pw_occ)));

    // R10: occupancy grows only after an accepted offer
    a_r10_l_accept: assert property (@(posedge clk) disable iff (rst)
        (int'(l_occ) > int'($past(l_occ))) |-> $past(l_in_valid && l_in_ready));
    a_r10_b_accept: assert property (@(posedge clk) disable iff (rst)
        (int'(b_occ) > int'($past(b_occ))) |-> $past(b_in_valid && b_in_ready));
    a_r10_pw_accept: assert property (@(posedge clk) disable iff (rst)
        (int'(pw_occ) > int'($past(pw_occ))) |-> $past(pw_in_valid && pw_in_ready));

    // R6: flits of one message leave in consecutive cycles
    a_r6_l_burst: assert property (@(posedge clk) disable iff (rst)
        (l_tx_valid && !l_tx_last) |=> l_tx_valid);
    a_r6_b_burst: assert property (@(posedge clk) disable iff (rst)
        (b_tx_valid && !b_tx_last) |=> b_tx_valid);
    a_r6_pw_burst: assert property (@(posedge clk) disable iff (rst)
        (pw_tx_valid && !pw_tx_last) |=> pw_tx_valid);

    // R7: a delivery follows a received last flit
    a_r7_l_dlv: assert property (@(posedge clk) disable iff (rst)
        l_dlv_valid |-> $past(l_lk_valid && l_lk_last));
    a_r7_b_dlv: assert property (@(posedge clk) disable iff (rst)
        b_dlv_valid |-> $past(b_lk_valid && b_lk_last));
    a_r7_pw_dlv: assert property (@(posedge clk) disable iff (rst)
        pw_dlv_valid |-> $past(pw_lk_valid && pw_lk_last));
endmodule

bind hetlink_port hetlink_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk (clk), .rst (rst),
    .l_in_valid (l_in_valid), .l_in_ready (l_in_ready),
    .b_in_valid (b_in_valid), .b_in_ready (b_in_ready),
    .pw_in_valid (pw_in_valid), .pw_in_ready (pw_in_ready),
    .l_tx_valid (l_tx_valid), .l_tx_last (l_tx_last),
    .b_tx_valid (b_tx_valid), .b_tx_last (b_tx_last),
    .pw_tx_valid (pw_tx_valid), .pw_tx_last (pw_tx_last),
    .l_lk_valid (l_lk_valid), .l_lk_last (l_lk_last),
    .b_lk_valid (b_lk_valid), .b_lk_last (b_lk_last),
    .pw_lk_valid (pw_lk_valid), .pw_lk_last (pw_lk_last),
    .l_dlv_valid (l_dlv_valid), .b_dlv_valid (b_dlv_valid), .pw_dlv_valid (pw_dlv_valid),
    .l_occ (l_occ), .b_occ (b_occ), .pw_occ (pw_occ), .occ_total (occ_total)
);

// File: tb/hetlink_port_tb_top.sv
`timescale 1ns/1ps
module hetlink_port_tb_top;
    localparam int DEPTH = 4;
    localparam int LINKW [3] = '{24, 256, 512};
    localparam int MSGW  [3] = '{48, 512, 512};
    localparam int STG   [3] = '{1, 2, 4};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic         iv [3];
    logic [511:0] id [3];

    logic l_in_ready, b_in_ready, pw_in_ready;
    logic l_tx_valid, l_tx_last, b_tx_valid, b_tx_last, pw_tx_valid, pw_tx_last;
    logic [23:0]  l_tx_data;
    logic [255:0] b_tx_data;
    logic [511:0] pw_tx_data;
    logic l_dlv_valid, b_dlv_valid, pw_dlv_valid;
    logic [47:0]  l_dlv_data;
    logic [511:0] b_dlv_data, pw_dlv_data;
    logic [2:0] l_occ, b_occ, pw_occ;
    logic [4:0] occ_total;

    hetlink_port dut_i (
        .clk (clk), .rst (rst),
        .l_in_valid (iv[0]), .l_in_ready (l_in_ready), .l_in_data (id[0][47:0]),
        .b_in_valid (iv[1]), .b_in_ready (b_in_ready), .b_in_data (id[1]),
        .pw_in_valid (iv[2]), .pw_in_ready (pw_in_ready), .pw_in_data (id[2]),
        .l_tx_valid (l_tx_valid), .l_tx_last (l_tx_last), .l_tx_data (l_tx_data),
        .b_tx_valid (b_tx_valid), .b_tx_last (b_tx_last), .b_tx_data (b_tx_data),
        .pw_tx_valid (pw_tx_valid), .pw_tx_last (pw_tx_last), .pw_tx_data (pw_tx_data),
        .l_lk_valid (l_tx_valid), .l_lk_last (l_tx_last), .l_lk_data (l_tx_data),
        .b_lk_valid (b_tx_valid), .b_lk_last (b_tx_last), .b_lk_data (b_tx_data),
        .pw_lk_valid (pw_tx_valid), .pw_lk_last (pw_tx_last), .pw_lk_data (pw_tx_data),
        .l_dlv_valid (l_dlv_valid), .l_dlv_data (l_dlv_data),
        .b_dlv_valid (b_dlv_valid), .b_dlv_data (b_dlv_data),
        .pw_dlv_valid (pw_dlv_valid), .pw_dlv_data (pw_dlv_data),
        .l_occ (l_occ), .b_occ (b_occ), .pw_occ (pw_occ), .occ_total (occ_total)
    );

    // Per-class views of the outputs
    logic         o_rdy [3];
    logic         o_txv [3];
    logic         o_txl [3];
    logic [511:0] o_txd [3];
    logic         o_dv  [3];
    logic [511:0] o_dd  [3];
    int           o_occ [3];
    assign o_rdy[0] = l_in_ready;  assign o_rdy[1] = b_in_ready;  assign o_rdy[2] = pw_in_ready;
    assign o_txv[0] = l_tx_valid;  assign o_txv[1] = b_tx_valid;  assign o_txv[2] = pw_tx_valid;
    assign o_txl[0] = l_tx_last;   assign o_txl[1] = b_tx_last;   assign o_txl[2] = pw_tx_last;
    assign o_txd[0] = 512'(l_tx_data); assign o_txd[1] = 512'(b_tx_data); assign o_txd[2] = pw_tx_data;
    assign o_dv[0]  = l_dlv_valid; assign o_dv[1]  = b_dlv_valid; assign o_dv[2]  = pw_dlv_valid;
    assign o_dd[0]  = 512'(l_dlv_data); assign o_dd[1] = b_dlv_data; assign o_dd[2] = pw_dlv_data;
    assign o_occ[0] = int'(l_occ); assign o_occ[1] = int'(b_occ); assign o_occ[2] = int'(pw_occ);

    int nchk = 0;
    int nfail = 0;
    int ncoinc = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic logic [511:0] wmask(input int w);
        return (512'b1 << w) - 512'b1;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    // Behavioural reference model
    logic [511:0] mq   [3][$];
    int           fidx [3];
    logic [511:0] fq_d [3][$];
    int           fq_t [3][$];
    logic         fq_l [3][$];
    logic [511:0] dq_d [3][$];
    int           dq_t [3][$];

    always @(posedge clk) begin
        int sz;
        int nf;
        bit take;
        bit lst;
        logic [511:0] fl;
        cyc = cyc + 1;
        for (int c = 0; c < 3; c++) begin
            if (rst) begin
                mq[c].delete(); fq_d[c].delete(); fq_t[c].delete(); fq_l[c].delete();
                dq_d[c].delete(); dq_t[c].delete(); fidx[c] = 0;
            end else begin
                sz   = mq[c].size();
                take = iv[c] && (sz < DEPTH);
                nf   = (MSGW[c] + LINKW[c] - 1) / LINKW[c];
                if (sz > 0) begin
                    fl  = (mq[c][0] >> (fidx[c] * LINKW[c])) & wmask(LINKW[c]);
                    lst = (fidx[c] == nf - 1);
                    fq_d[c].push_back(fl);
                    fq_t[c].push_back(cyc + STG[c] - 1);
                    fq_l[c].push_back(lst);
                    if (lst) begin
                        dq_d[c].push_back(mq[c][0]);
                        dq_t[c].push_back(cyc + STG[c]);
                        void'(mq[c].pop_front());
                        fidx[c] = 0;
                    end else begin
                        fidx[c]++;
                    end
                end
                if (take) mq[c].push_back(id[c] & wmask(MSGW[c]));
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        int tot;
        if (!rst) begin
            tot = 0;
            for (int c = 0; c < 3; c++) begin
                tot += mq[c].size();
                chk(o_rdy[c] == (mq[c].size() < DEPTH), "R2/R10", $sformatf("ready class %0d", c),
                    512'(o_rdy[c]), 512'(mq[c].size() < DEPTH));
                chk(o_occ[c] == mq[c].size(), "R9", $sformatf("occupancy class %0d", c),
                    512'(o_occ[c]), 512'(mq[c].size()));
                if (fq_t[c].size() > 0 && fq_t[c][0] == cyc) begin
                    chk(o_txv[c] === 1'b1, "R5", $sformatf("flit valid class %0d", c), 512'(o_txv[c]), 512'd1);
                    chk(o_txd[c] === fq_d[c][0], "R4/R6", $sformatf("flit data class %0d", c), o_txd[c], fq_d[c][0]);
                    chk(o_txl[c] === fq_l[c][0], "R6", $sformatf("flit last class %0d", c), 512'(o_txl[c]), 512'(fq_l[c][0]));
                    void'(fq_d[c].pop_front()); void'(fq_t[c].pop_front()); void'(fq_l[c].pop_front());
                end else begin
                    chk(o_txv[c] === 1'b0, "R5", $sformatf("idle bundle class %0d", c), 512'(o_txv[c]), 512'd0);
                end
                if (dq_t[c].size() > 0 && dq_t[c][0] == cyc) begin
                    chk(o_dv[c] === 1'b1, "R7", $sformatf("delivery valid class %0d", c), 512'(o_dv[c]), 512'd1);
                    chk(o_dd[c] === dq_d[c][0], "R8", $sformatf("delivery order/data class %0d", c), o_dd[c], dq_d[c][0]);
                    void'(dq_d[c].pop_front()); void'(dq_t[c].pop_front());
                end else begin
                    chk(o_dv[c] === 1'b0, "R7/R10", $sformatf("no delivery class %0d", c), 512'(o_dv[c]), 512'd0);
                end
            end
            chk(int'(occ_total) == tot, "R9", "total occupancy", 512'(occ_total), 512'(tot));
            if (l_tx_valid && b_tx_valid && pw_tx_valid) ncoinc++;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 3; c++) begin iv[c] = 1'b0; id[c] = '0; end
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(l_in_ready && b_in_ready && pw_in_ready, "R1", "readies in reset",
            512'({l_in_ready, b_in_ready, pw_in_ready}), 512'd7);
        chk(occ_total == '0, "R1", "occupancy in reset", 512'(occ_total), 512'd0);
        chk(!l_tx_valid && !b_tx_valid && !pw_tx_valid && !l_dlv_valid && !b_dlv_valid && !pw_dlv_valid,
            "R1", "valids in reset", 512'({l_tx_valid, b_tx_valid, pw_tx_valid}), 512'd0);
        rst = 1'b0;

        // Random mixed traffic
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            for (int c = 0; c < 3; c++) begin
                iv[c] = ($urandom % 2) == 1;
                id[c] = rnd512() & wmask(MSGW[c]);
            end
        end

        // Flood: two-flit classes fill, single-flit class keeps flowing
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (n == 30) begin
                chk(!l_in_ready && !b_in_ready, "R2", "two-flit queues full under flood",
                    512'({l_in_ready, b_in_ready}), 512'd0);
                chk(pw_in_ready, "R2", "single-flit class still ready", 512'(pw_in_ready), 512'd1);
            end
            for (int c = 0; c < 3; c++) begin
                iv[c] = 1'b1;
                id[c] = rnd512() & wmask(MSGW[c]);
            end
        end

        // Drain
        @(negedge clk);
        for (int c = 0; c < 3; c++) iv[c] = 1'b0;
        repeat (60) @(negedge clk);
        chk(occ_total == '0, "R9", "drained occupancy", 512'(occ_total), 512'd0);
        chk(dq_t[0].size() + dq_t[1].size() + dq_t[2].size() == 0, "R8", "all messages delivered",
            512'(dq_t[0].size() + dq_t[1].size() + dq_t[2].size()), 512'd0);
        chk(ncoinc > 0, "R3", "three bundles active in one cycle", 512'(ncoinc), 512'd1);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule